// File: doc/BRIEF.md
# Gated Noise Combiner with CRC Whitening and Read Hold-off

This block turns three raw noise bits into 64-bit random words. Every clock cycle it samples the three source bits and masks each one with its own enable. It reduces the masked bits to one bit and clocks that bit into a 64-bit CRC register. A requester asks for a word by raising a request line. While the hold-off mode is on, the block answers only after a programmed number of cycles has gone by since the previous answer. This gives the register time to gather enough fresh noise before it is exposed again.

One configuration word sets the block up. It holds the hold-off length, the hold-off mode bit, a combine-select field, an oscillator code and the three source enables. The oscillator code is kept separately for each source. A write that enables exactly one source stores the code for that source. Software therefore tunes the sources one at a time and then makes a last write that sets the run state and turns all the sources on.

Top module: `noise_crc_conditioner`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_valid` is 0 and `osc_sel` is 0. Reset also clears the CRC register and the hold-off counter, and loads the configuration: hold-off length `RST_WAIT`, hold-off mode on, combine select 0, oscillator code 0, all three sources enabled.
- R2: When combine select is 0, the bit fed to the CRC is the XOR of `src_bits & enables`. With no source enabled, that bit is 0.
- R3: Each cycle the CRC register shifts left by one. If the old bit 63 XOR the feed bit is 1, the shifted value is also XORed with the constant whose set bits are 0, 1, 5, 7, 11, 12, 13, 15, 17, 21, 22, 25, 28, 32, 35, 37, 38, 39, 41, 42, 43, 46, 47, 48, 50, 51, 52, 56, 57 and 61.
- R4: When hold-off mode is on, a held request is granted at the first clock edge where the hold-off counter is at least the hold-off length. `rd_valid` rises after that edge, and `rd_data` carries the CRC value from just before that edge.
- R5: A grant restarts the hold-off counter at 0. The counter then counts one per cycle and saturates. With a request held, successive grants are spaced hold-off length + 1 cycles apart.
- R6: When hold-off mode is off, a pending request is granted at the next edge, whatever the counter value.
- R7: `rd_valid` is high for exactly one cycle, and no grant is made while it is high. A request held with hold-off mode off therefore gets one word every two cycles.
- R8: A configuration write whose enable field has exactly one bit set stores its oscillator code into that source's slot of `osc_sel`. Source k sits at bits [2k+1:2k]. Any other write leaves `osc_sel` unchanged.
- R9: When combine select is k (1 to 3), the feed bit is source k-1 ANDed with its enable.
- R10: The configuration word is bits [15:0] hold-off length, [16] mode, [18:17] combine select, [20:19] oscillator code, [23:21] enables (bit 21 is source 0). A write takes effect from the cycle after its edge, including a write made while a request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_bits | input | 3 | Raw noise bits, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word |
| rd_req | input | 1 | Read request, held until answered |
| rd_valid | output | 1 | One-cycle answer strobe |
| rd_data | output | 64 | Random word, valid with `rd_valid` |
| osc_sel | output | 6 | Per-source oscillator codes |

## Verification
If a single feed bit or polynomial tap is wrong, the CRC register diverges from the model. That shows up in the very next word returned, and with the hold-off off a word comes out every second cycle. An error in the hold-off counter or its comparison moves the `rd_valid` strobe by at least one cycle against the model, and the bench checks the strobe every clock. A wrongly latched oscillator code is visible on `osc_sel` one cycle after the write.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

    localparam int NSRC   = 3;
    localparam int WAIT_W = 16;
    localparam int SEL_W  = 2;
    localparam int OSC_W  = 2;
    localparam int CRC_W  = 64;
    localparam int OSCV_W = NSRC * OSC_W;

    // Generator polynomial without its implicit top term
    localparam logic [CRC_W-1:0] CRC_POLY =
        (64'd1 << 61) | (64'd1 << 57) | (64'd1 << 56) | (64'd1 << 52) |
        (64'd1 << 51) | (64'd1 << 50) | (64'd1 << 48) | (64'd1 << 47) |
        (64'd1 << 46) | (64'd1 << 43) | (64'd1 << 42) | (64'd1 << 41) |
        (64'd1 << 39) | (64'd1 << 38) | (64'd1 << 37) | (64'd1 << 35) |
        (64'd1 << 32) | (64'd1 << 28) | (64'd1 << 25) | (64'd1 << 22) |
        (64'd1 << 21) | (64'd1 << 17) | (64'd1 << 15) | (64'd1 << 13) |
        (64'd1 << 12) | (64'd1 << 11) | (64'd1 << 7)  | (64'd1 << 5)  |
        (64'd1 << 1)  | 64'd1;

    typedef struct packed {
        logic [NSRC-1:0]   en;
        logic [OSC_W-1:0]  osc;
        logic [SEL_W-1:0]  sel;
        logic              mode;
        logic [WAIT_W-1:0] wait_len;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] s,
                                                  input logic b);
        logic [CRC_W-1:0] sh;
        sh = {s[CRC_W-2:0], 1'b0};
        return (s[CRC_W-1] ^ b) ? (sh ^ CRC_POLY) : sh;
    endfunction

endpackage

// File: rtl/ncc_cfg.sv
module ncc_cfg
    import ncc_pkg::*;
#(
    parameter int RST_WAIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output ctrl_t             ctrl_q,
    output logic [OSCV_W-1:0] osc_q
);
    ctrl_t wr;
    assign wr = ctrl_t'(cfg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.en       <= '1;
            ctrl_q.osc      <= '0;
            ctrl_q.sel      <= '0;
            ctrl_q.mode     <= 1'b1;
            ctrl_q.wait_len <= WAIT_W'(RST_WAIT);
        end else if (cfg_we) begin
            ctrl_q <= wr;
        end
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_osc
        always_ff @(posedge clk) begin
            if (rst)
                osc_q[k*OSC_W +: OSC_W] <= '0;
            else if (cfg_we && (wr.en == NSRC'(1 << k)))
                osc_q[k*OSC_W +: OSC_W] <= wr.osc;
        end
    end

    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && ($countones(wr.en) != 1)) |=> $stable(osc_q)); // R8

endmodule

// File: rtl/ncc_mixer.sv
module ncc_mixer
    import ncc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_bits,
    input  logic [NSRC-1:0]  en,
    input  logic [SEL_W-1:0] sel,
    output logic             feed
);
    logic [NSRC-1:0]  gated;
    logic [SEL_W-1:0] idx;

    always_comb begin
        gated = src_bits & en;
        idx   = sel - SEL_W'(1);
        if (sel == '0)
            feed = ^gated;
        else if (int'(idx) < NSRC)
            feed = gated[idx];
        else
            feed = 1'b0;
    end

    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !feed); // R2

endmodule

// File: rtl/ncc_crc.sv
module ncc_crc
    import ncc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             feed,
    output logic [CRC_W-1:0] crc_q
);
    always_ff @(posedge clk) begin
        if (rst) crc_q <= '0;
        else     crc_q <= crc_step(crc_q, feed);
    end

    AST_LSB_FROM_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
        !(crc_q[CRC_W-1] ^ feed) |=> (crc_q[0] == 1'b0)); // R3

endmodule

// File: rtl/ncc_interlock.sv
module ncc_interlock
    import ncc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic [WAIT_W-1:0] wait_len,
    input  logic              rd_req,
    input  logic [CRC_W-1:0]  crc,
    output logic              rd_valid,
    output logic [CRC_W-1:0]  rd_data
);
    logic [WAIT_W-1:0] cnt;
    logic              grant;

    assign grant = rd_req && !rd_valid && (!mode || (cnt >= wait_len));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= grant;
            if (grant) begin
                cnt     <= '0;
                rd_data <= crc;
            end else if (cnt != '1) begin
                cnt <= cnt + WAIT_W'(1);
            end
        end
    end

    AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (mode && (cnt < wait_len)) |=> !rd_valid); // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (cnt == WAIT_W'(1))); // R5
    AST_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R7

endmodule

// File: rtl/noise_crc_conditioner.sv
module noise_crc_conditioner
    import ncc_pkg::*;
#(
    parameter int RST_WAIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_bits,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [CRC_W-1:0]  rd_data,
    output logic [OSCV_W-1:0] osc_sel
);
    ctrl_t            ctrl;
    logic             feed;
    logic [CRC_W-1:0] crc;

    ncc_cfg #(.RST_WAIT(RST_WAIT)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctrl_q(ctrl), .osc_q(osc_sel)
    );

    ncc_mixer u_mix (
        .clk(clk), .rst(rst), .src_bits(src_bits), .en(ctrl.en),
        .sel(ctrl.sel), .feed(feed)
    );

    ncc_crc u_crc (
        .clk(clk), .rst(rst), .feed(feed), .crc_q(crc)
    );

    ncc_interlock u_ilk (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .wait_len(ctrl.wait_len),
        .rd_req(rd_req), .crc(crc), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    AST_OSC_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (osc_sel == '0 && !rd_valid)); // R1

endmodule

// File: tb/sim_noise_crc_conditioner.sv
module sim_noise_crc_conditioner;

    localparam int WAITR = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_bits = '0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [5:0]  osc_sel;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";

    noise_crc_conditioner #(.RST_WAIT(WAITR)) u0 (
        .clk(clk), .rst(rst), .src_bits(src_bits), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .osc_sel(osc_sel)
    );

    always #4 clk = ~clk;

    localparam logic [63:0] P =
        (64'd1 << 0)  | (64'd1 << 1)  | (64'd1 << 5)  | (64'd1 << 7)  |
        (64'd1 << 11) | (64'd1 << 12) | (64'd1 << 13) | (64'd1 << 15) |
        (64'd1 << 17) | (64'd1 << 21) | (64'd1 << 22) | (64'd1 << 25) |
        (64'd1 << 28) | (64'd1 << 32) | (64'd1 << 35) | (64'd1 << 37) |
        (64'd1 << 38) | (64'd1 << 39) | (64'd1 << 41) | (64'd1 << 42) |
        (64'd1 << 43) | (64'd1 << 46) | (64'd1 << 47) | (64'd1 << 48) |
        (64'd1 << 50) | (64'd1 << 51) | (64'd1 << 52) | (64'd1 << 56) |
        (64'd1 << 57) | (64'd1 << 61);

    // reference model state
    logic [63:0] m_crc, m_data;
    logic        m_valid, m_mode;
    int          m_cnt, m_wait, m_sel;
    logic [2:0]  m_en;
    int          m_osc[3];

    function automatic logic pick_bit(logic [2:0] s, logic [2:0] e, int sel);
        logic b = 1'b0;
        if (sel == 0) begin
            for (int i = 0; i < 3; i++) if (e[i]) b = b ^ s[i];
        end else begin
            b = s[sel-1] & e[sel-1];
        end
        return b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_crc = '0; m_data = '0; m_valid = 0; m_cnt = 0;
            m_wait = WAITR; m_mode = 1; m_sel = 0; m_en = 3'b111;
            for (int i = 0; i < 3; i++) m_osc[i] = 0;
        end else begin
            logic fb, g;
            logic [63:0] nx;
            g = rd_req && !m_valid && (!m_mode || m_cnt >= m_wait);
            if (g) begin
                m_data = m_crc; m_cnt = 0;
            end else if (m_cnt < 65535) begin
                m_cnt = m_cnt + 1;
            end
            m_valid = g;
            fb = m_crc[63] ^ pick_bit(src_bits, m_en, m_sel);
            for (int i = 63; i > 0; i--) nx[i] = m_crc[i-1] ^ (fb & P[i]);
            nx[0] = fb & P[0];
            m_crc = nx;
            if (cfg_we) begin
                m_wait = int'(cfg_wdata[15:0]);
                m_mode = cfg_wdata[16];
                m_sel  = int'(cfg_wdata[18:17]);
                m_en   = cfg_wdata[23:21];
                for (int i = 0; i < 3; i++)
                    if (cfg_wdata[23:21] == 3'(1 << i)) m_osc[i] = int'(cfg_wdata[20:19]);
            end
        end
    end

    task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // cycle-by-cycle compare, away from the active edge
    always @(negedge clk) begin
        logic [5:0] eo;
        eo = {2'(m_osc[2]), 2'(m_osc[1]), 2'(m_osc[0])};
        check(rd_valid === m_valid, "rd_valid", 64'(rd_valid), 64'(m_valid));
        if (m_valid) check(rd_data === m_data, "rd_data", rd_data, m_data);
        check(osc_sel === eo, "osc_sel", 64'(osc_sel), 64'(eo));
    end

    task automatic tick();
        @(posedge clk); #2;
        src_bits = 3'($urandom);
    endtask

    task automatic write_cfg(logic [2:0] en, logic [1:0] osc, logic [1:0] sel,
                             logic mode, logic [15:0] w);
        cfg_wdata = {en, osc, sel, mode, w};
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin tick(); n++; end while (!rd_valid && n < 2000);
        if (!rd_valid) check(0, "no answer", 0, 1);
    endtask

    function automatic string name_of(int k);
        return (k == 1) ? "R9" : "R2";
    endfunction

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int gap, cnt;
        tag = "R1";
        repeat (3) tick();
        check(rd_valid === 1'b0, "valid in reset", 64'(rd_valid), 0);
        check(osc_sel === '0, "osc in reset", 64'(osc_sel), 0);
        rst = 1'b0;

        tag = "R4";  // request straight after reset stalls for the default length
        rd_req = 1'b1;
        wait_valid(gap);
        check(gap == WAITR + 1, "first grant delay", 64'(gap), 64'(WAITR + 1));

        tag = "R5";
        wait_valid(gap);
        check(gap == WAITR + 1, "grant spacing", 64'(gap), 64'(WAITR + 1));

        tag = "R10";  // shorten hold-off while a request waits
        write_cfg(3'b111, 2'd0, 2'd0, 1'b1, 16'd5);
        wait_valid(gap);
        wait_valid(gap);
        check(gap == 6, "new spacing", 64'(gap), 64'd6);

        tag = "R7";  // hold-off off: one word every second cycle
        write_cfg(3'b111, 2'd0, 2'd0, 1'b0, 16'd5);
        tick();
        cnt = 0;
        for (int i = 0; i < 40; i++) begin tick(); if (rd_valid) cnt++; end
        check(cnt == 20, "words in 40 cycles", 64'(cnt), 64'd20);

        tag = "R6";
        write_cfg(3'b111, 2'd0, 2'd0, 1'b0, 16'hFFFF);
        repeat (30) tick();

        tag = "R3";
        repeat (200) tick();

        tag = "R2";
        for (int e = 0; e < 8; e++) begin
            write_cfg(3'(e), 2'd0, 2'd0, 1'b0, 16'd0);
            repeat (30) tick();
        end

        for (int s = 1; s < 4; s++) begin
            tag = name_of(1);
            write_cfg(3'b111, 2'd0, 2'(s), 1'b0, 16'd0);
            repeat (30) tick();
            write_cfg(~3'(1 << (s - 1)), 2'd0, 2'(s), 1'b0, 16'd0);
            repeat (30) tick();
        end

        tag = "R8";
        write_cfg(3'b001, 2'd1, 2'd0, 1'b1, 16'd3);
        write_cfg(3'b010, 2'd2, 2'd0, 1'b1, 16'd3);
        write_cfg(3'b100, 2'd3, 2'd0, 1'b1, 16'd3);
        check(osc_sel === 6'b11_10_01, "osc per source", 64'(osc_sel), 64'h39);
        write_cfg(3'b111, 2'd0, 2'd0, 1'b1, 16'd3);
        write_cfg(3'b000, 2'd2, 2'd0, 1'b1, 16'd3);
        write_cfg(3'b011, 2'd2, 2'd0, 1'b1, 16'd3);
        check(osc_sel === 6'b11_10_01, "osc held", 64'(osc_sel), 64'h39);
        repeat (40) tick();

        rd_req = 1'b0;
        repeat (4) tick();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule